// File: doc/BRIEF.md
# Early-Resolve Branch Fetch Controller

This block generates the fetch address for a five-stage in-order pipeline whose branches are settled in the decode stage. Each cycle it presents the address being fetched. It also gives two registered qualifiers for the instruction that was fetched one cycle earlier and now enters decode. One says that instruction is valid. The other says it has been discarded. Decode supplies a branch flag, the equality result of the two register operands and the computed target. The controller folds these into the next address.

Because the outcome is known in decode, exactly one fetch slot lies between a branch and its successor. A policy chosen at reset decides how that slot is used. It can always become a bubble (stall), it can hold the sequential instruction and be squashed only on a taken branch (predict not taken), or it can always execute (delay slot). A discarded instruction leaves with its valid bit cleared, so it has no effect further down the pipeline. A branch flag that arrives alongside an invalid decode slot is ignored.

Top module: `brfetch_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `fetch_pc` is 0, and `dec_valid` and `dec_kill` are both low.
- R2: With no accepted branch in decode, `fetch_pc` advances by 4 each cycle. `dec_valid` is then high and `dec_kill` low.
- R3: The policy is taken from `policy_sel` only on clock edges with `rst` high and is held until the next reset. Encoding: 0 stall, 1 predict-not-taken, 2 delay-slot, 3 behaves as stall.
- R4: Stall policy, taken branch: in the next cycle `fetch_pc` equals the target, `dec_kill` is high and `dec_valid` low.
- R5: Stall policy, not-taken branch: in the next cycle `fetch_pc` keeps its value, so the slot address is fetched again, and `dec_kill` is high.
- R6: Predict-not-taken policy, taken branch: in the next cycle `fetch_pc` equals the target and `dec_kill` is high.
- R7: Predict-not-taken policy, not-taken branch: `fetch_pc` advances by 4 and `dec_kill` stays low.
- R8: Delay-slot policy: `dec_kill` never rises. A taken branch loads the target, and a not-taken branch advances by 4.
- R9: `br_in_dec` has no effect in a cycle where `dec_valid` is low. The address advances by 4.
- R10: `dec_kill` high implies `dec_valid` low in the same cycle.
- R11: The address wraps modulo 2^ADDR_W when it advances past the top of the address space.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy_sel | input | 2 | Slot policy, sampled during reset |
| br_in_dec | input | 1 | Decode holds a conditional branch |
| br_equal | input | 1 | Register operands compare equal (branch taken) |
| br_target | input | ADDR_W | Branch target computed in decode |
| fetch_pc | output | ADDR_W | Address fetched this cycle |
| dec_valid | output | 1 | Instruction now entering decode is valid |
| dec_kill | output | 1 | Instruction now entering decode was discarded |

## Verification
The bench builds the controller with a 16-bit address and the default 4-byte step. This makes a target near 0xFFF8 practical and brings the wrap of the sequential address back to zero within two cycles. Directed tasks run every policy through taken and not-taken outcomes. They also cover a branch flag that lands on a discarded slot, the unused policy code, and a policy input changed after reset.

// File: rtl/brfetch_pkg.sv
package brfetch_pkg;

  typedef enum logic [1:0] {
    POL_STALL  = 2'd0,
    POL_SPEC   = 2'd1,
    POL_SLOT   = 2'd2,
    POL_STALL2 = 2'd3
  } slot_policy_e;

  typedef struct packed {
    logic redirect;
    logic hold;
    logic kill;
  } slot_action_t;

endpackage

// File: rtl/brfetch_policy_reg.sv
module brfetch_policy_reg
  import brfetch_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   policy_sel,
  output slot_policy_e policy
);

  slot_policy_e policy_q;

  always_ff @(posedge clk) begin
    if (rst) policy_q <= slot_policy_e'(policy_sel);
  end

  assign policy = policy_q;

  AST_POLICY_HELD: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(policy_q)); // R3

endmodule

// File: rtl/brfetch_decide.sv
module brfetch_decide
  import brfetch_pkg::*;
(
  input  slot_policy_e policy,
  input  logic         br_live,
  input  logic         taken,
  output slot_action_t act
);

  always_comb begin
    act = '0;
    if (br_live) begin
      unique case (policy)
        POL_SPEC: begin
          act.redirect = taken;
          act.kill     = taken;
        end
        POL_SLOT: begin
          act.redirect = taken;
        end
        default: begin
          act.redirect = taken;
          act.hold     = !taken;
          act.kill     = 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    if (act.redirect && act.hold)
      AST_ONE_SOURCE: assert (0) else $error("redirect and hold together"); // R5
  end

endmodule

// File: rtl/brfetch_next_addr.sv
module brfetch_next_addr
  import brfetch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [ADDR_W-1:0] target,
  input  slot_action_t      act,
  output logic [ADDR_W-1:0] nxt_pc
);

  localparam logic [ADDR_W-1:0] INC = ADDR_W'(STEP);

  logic [ADDR_W-1:0] seq_pc;
  assign seq_pc = cur_pc + INC;

  always_comb begin
    if (act.redirect)  nxt_pc = target;
    else if (act.hold) nxt_pc = cur_pc;
    else               nxt_pc = seq_pc;
  end

endmodule

// File: rtl/brfetch_ctrl.sv
module brfetch_ctrl
  import brfetch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4,
  parameter logic [ADDR_W-1:0] BOOT_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        policy_sel,
  input  logic              br_in_dec,
  input  logic              br_equal,
  input  logic [ADDR_W-1:0] br_target,
  output logic [ADDR_W-1:0] fetch_pc,
  output logic              dec_valid,
  output logic              dec_kill
);

  localparam logic [ADDR_W-1:0] INC = ADDR_W'(STEP);

  slot_policy_e      policy;
  slot_action_t      act;
  logic [ADDR_W-1:0] pc_q, pc_nxt;
  logic              valid_q, kill_q;
  logic              br_live;

  brfetch_policy_reg u_pol (
    .clk        (clk),
    .rst        (rst),
    .policy_sel (policy_sel),
    .policy     (policy)
  );

  // a branch flag on a discarded slot is not a real branch
  assign br_live = br_in_dec && valid_q;

  brfetch_decide u_dec (
    .policy  (policy),
    .br_live (br_live),
    .taken   (br_equal),
    .act     (act)
  );

  brfetch_next_addr #(
    .ADDR_W (ADDR_W),
    .STEP   (STEP)
  ) u_nxt (
    .cur_pc (pc_q),
    .target (br_target),
    .act    (act),
    .nxt_pc (pc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= BOOT_PC;
      valid_q <= 1'b0;
      kill_q  <= 1'b0;
    end else begin
      pc_q    <= pc_nxt;
      valid_q <= !act.kill;
      kill_q  <= act.kill;
    end
  end

  assign fetch_pc  = pc_q;
  assign dec_valid = valid_q;
  assign dec_kill  = kill_q;

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(br_live)) |-> pc_q == $past(pc_q) + INC); // R2

  AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (rst)
    $past(br_live && br_equal) |-> pc_q == $past(br_target)); // R4

  AST_KILL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    kill_q |-> $past(br_live)); // R6

  AST_SLOT_NO_KILL: assert property (@(posedge clk) disable iff (rst)
    policy == POL_SLOT |-> !kill_q); // R8

  AST_KILL_INVALID: assert property (@(posedge clk) disable iff (rst)
    kill_q |-> !valid_q); // R10

endmodule

// File: tb/test_brfetch_ctrl.sv
module test_brfetch_ctrl;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    policy_sel = 2'd0;
  logic          br_in_dec = 1'b0;
  logic          br_equal = 1'b0;
  logic [AW-1:0] br_target = '0;
  logic [AW-1:0] fetch_pc;
  logic          dec_valid;
  logic          dec_kill;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  brfetch_ctrl #(.ADDR_W(AW), .STEP(4)) i_brfetch_ctrl (
    .clk        (clk),
    .rst        (rst),
    .policy_sel (policy_sel),
    .br_in_dec  (br_in_dec),
    .br_equal   (br_equal),
    .br_target  (br_target),
    .fetch_pc   (fetch_pc),
    .dec_valid  (dec_valid),
    .dec_kill   (dec_kill)
  );

  task automatic chk(input string req, input logic [AW-1:0] pc, input logic v, input logic k);
    checks++;
    if (fetch_pc !== pc || dec_valid !== v || dec_kill !== k) begin
      errors++;
      $display("FAIL %s: pc=%h valid=%b kill=%b, expected pc=%h valid=%b kill=%b",
               req, fetch_pc, dec_valid, dec_kill, pc, v, k);
    end
  endtask

  // called at a falling edge; applies inputs across one rising edge
  task automatic tick(input logic b, input logic e, input logic [AW-1:0] t);
    br_in_dec = b; br_equal = e; br_target = t;
    @(posedge clk);
    @(negedge clk);
    br_in_dec = 1'b0; br_equal = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] pol);
    @(negedge clk);
    rst = 1'b1; policy_sel = pol; br_in_dec = 1'b0; br_equal = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset state", 16'h0000, 1'b0, 1'b0);
  endtask

  task automatic t_stall;
    do_reset(2'd0);
    tick(0, 0, 16'h0);     chk("R2 step", 16'h0004, 1, 0);
    tick(0, 0, 16'h0);     chk("R2 step", 16'h0008, 1, 0);
    tick(1, 1, 16'h0040);  chk("R4 stall taken", 16'h0040, 0, 1);
    tick(1, 1, 16'h0900);  chk("R9 branch on dead slot", 16'h0044, 1, 0);
    tick(1, 0, 16'h0080);  chk("R5 stall not taken refetch", 16'h0044, 0, 1);
    tick(0, 0, 16'h0);     chk("R2 step after refetch", 16'h0048, 1, 0);
  endtask

  task automatic t_code3;
    do_reset(2'd3);
    tick(0, 0, 16'h0);     chk("R2 step", 16'h0004, 1, 0);
    tick(1, 0, 16'h0020);  chk("R3 code 3 acts as stall", 16'h0004, 0, 1);
  endtask

  task automatic t_spec;
    do_reset(2'd1);
    tick(0, 0, 16'h0);     chk("R2 step", 16'h0004, 1, 0);
    tick(0, 0, 16'h0);     chk("R2 step", 16'h0008, 1, 0);
    tick(1, 0, 16'h0070);  chk("R7 predict not taken, not taken", 16'h000C, 1, 0);
    tick(1, 1, 16'h0080);  chk("R6 predict not taken, taken", 16'h0080, 0, 1);
    tick(1, 1, 16'h0300);  chk("R9 branch on squashed slot", 16'h0084, 1, 0);
  endtask

  task automatic t_latch;
    do_reset(2'd1);
    policy_sel = 2'd2;
    tick(0, 0, 16'h0);     chk("R2 step", 16'h0004, 1, 0);
    tick(1, 1, 16'h0060);  chk("R3 policy held after reset", 16'h0060, 0, 1);
  endtask

  task automatic t_slot;
    do_reset(2'd2);
    tick(0, 0, 16'h0);     chk("R2 step", 16'h0004, 1, 0);
    tick(1, 1, 16'hFFF8);  chk("R8 delay slot taken", 16'hFFF8, 1, 0);
    tick(0, 0, 16'h0);     chk("R2 step", 16'hFFFC, 1, 0);
    tick(0, 0, 16'h0);     chk("R11 wrap to zero", 16'h0000, 1, 0);
    tick(1, 0, 16'h0500);  chk("R8 delay slot not taken", 16'h0004, 1, 0);
  endtask

  initial begin
    t_stall();
    t_code3();
    t_spec();
    t_latch();
    t_slot();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule